// File: doc/BRIEF.md
# Tiled-Image Video Timing Generator

This block generates raster video timing (horizontal sync, vertical sync and a blank flag) together with the matching pixel colour. Its default configuration is an 800x600 visible area driven by a 40 MHz pixel clock. Every visible, front-porch, sync and back-porch length is a parameter, and so is the width of each colour channel. Pixels are fetched from an upstream provider. The block raises a request with an image column and row. The provider answers in the same cycle with a valid flag and a packed colour word.

The image size is supplied at run time on two inputs. When the image is smaller than the visible area, it is tiled. The column restarts at zero at every multiple of the image width and at the start of every line. The row restarts at every multiple of the image height and at the start of every frame. If the provider cannot supply a pixel, the block shows black and keeps the timing running.

Each axis is a four-state machine: `PH_ACTIVE` -> `PH_FRONT` -> `PH_SYNC` -> `PH_BACK` -> `PH_ACTIVE`. A state is left on the last count of its parameterised length. The horizontal machine steps on every clock. The vertical machine steps once per line, on the horizontal `PH_BACK` -> `PH_ACTIVE` transition. Both machines reset into `PH_ACTIVE` with a count of zero. Two register stages follow the machines: a request stage and an output stage. Sync and blank pass through both stages, so they stay aligned with the colour.

Top module: `vtg_video_timer`

## Requirements
- R1: Each visible line shows exactly H_ACT non-blank pixels, and each frame contains exactly V_ACT lines that hold non-blank pixels.
- R2: The line period is H_ACT+H_FP+H_SW+H_BP clocks. Hsync is asserted for H_SW clocks. The first non-blank pixel of a line comes H_BP clocks after hsync deasserts. With the default polarity, asserted means 1.
- R3: The frame period is (V_ACT+V_FP+V_SW+V_BP) line periods. Vsync is asserted for V_SW whole line periods, and asserted means 1 by default.
- R4: While blank_o is 1, all three colour outputs are 0.
- R5: pix_req is high once per visible pixel. The pixel colour appears on the outputs in the cycle after the request, as {red,green,blue} = pix_data[3*CW-1:2*CW], [2*CW-1:CW], [CW-1:0].
- R6: blank_o is 0 in exactly the cycles that follow a cycle with pix_req high, so sync, blank and colour share one latency.
- R7: On a request for the x-th visible pixel of a line (x from 0), pix_col equals x modulo img_width. An img_width of 0 is treated as 1.
- R8: On a request in the y-th visible line of a frame (y from 0), pix_row equals y modulo img_height. An img_height of 0 is treated as 1.
- R9: If pix_valid is 0 in a request cycle, that pixel is output as black. Line and frame timing are unaffected.
- R10: While rst_n is low, pix_req is 0, blank_o is 1, both syncs are deasserted and the colours are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| img_width | input | $clog2(H_ACT+1) | Image width in pixels for column tiling |
| img_height | input | $clog2(V_ACT+1) | Image height in lines for row tiling |
| pix_req | output | 1 | Pixel request to the provider |
| pix_col | output | $clog2(H_ACT) | Requested image column |
| pix_row | output | $clog2(V_ACT) | Requested image row |
| pix_valid | input | 1 | Provider has a pixel for this request |
| pix_data | input | 3*CW | Packed colour {red,green,blue} |
| red_o | output | CW | Red channel |
| green_o | output | CW | Green channel |
| blue_o | output | CW | Blue channel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | High outside the visible area |

## Verification
The column restart at a line start can land in the same cycle as a width wrap, and the row restart at a frame start can land in the same cycle as a height wrap. An image of 1x1 provokes both, because every pixel is then a wrap point. A 5x2 image places wraps in the middle of a line, and a 15x7 image never wraps. Dropped-pixel cycles are also arranged to fall on wrap points. A scoreboard checks each requested coordinate against x and y modulo the image size, and checks each shown colour against what the provider returned. Dropped pixels are expected as black. Period and width checks confirm that the timing keeps its pace while pixels are dropped.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_e;
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int ACT = 800,
    parameter int FP  = 40,
    parameter int SW  = 128,
    parameter int BP  = 88
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,
    output phase_e phase_o,
    output logic   first_o,
    output logic   wrap_o
);
    localparam int MAXL  = (ACT > SW) ? ((ACT > FP) ? ((ACT > BP) ? ACT : BP) : ((FP > BP) ? FP : BP))
                                      : ((SW > FP) ? ((SW > BP) ? SW : BP) : ((FP > BP) ? FP : BP));
    localparam int CNT_W = $clog2(MAXL + 1);

    phase_e           phase, phase_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;
    logic             last;

    always_comb begin
        unique case (phase)
            PH_ACTIVE: begin len = CNT_W'(ACT); phase_nxt = PH_FRONT;  end
            PH_FRONT:  begin len = CNT_W'(FP);  phase_nxt = PH_SYNC;   end
            PH_SYNC:   begin len = CNT_W'(SW);  phase_nxt = PH_BACK;   end
            PH_BACK:   begin len = CNT_W'(BP);  phase_nxt = PH_ACTIVE; end
            default:   begin len = CNT_W'(ACT); phase_nxt = PH_ACTIVE; end
        endcase
        last = (cnt == len - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_ACTIVE;
            cnt   <= '0;
        end else if (step) begin
            if (last) begin
                phase <= phase_nxt;
                cnt   <= '0;
            end else begin
                cnt   <= cnt + CNT_W'(1);
            end
        end
    end

    always_comb begin
        phase_o = phase;
        first_o = (phase == PH_ACTIVE) && (cnt == '0);
        wrap_o  = step && last && (phase == PH_BACK);
    end
endmodule

// File: rtl/vtg_tile.sv
module vtg_tile #(
    parameter int COL_W = 10,
    parameter int ROW_W = 10,
    parameter int SZW_W = 10,
    parameter int SZH_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act0,
    input  logic             line_first,
    input  logic             frame_first,
    input  logic [SZW_W-1:0] img_w,
    input  logic [SZH_W-1:0] img_h,
    output logic [COL_W-1:0] col_q,
    output logic [ROW_W-1:0] row_q
);
    logic [SZW_W:0] col_inc;
    logic [SZH_W:0] row_inc;

    always_comb begin
        col_inc = (SZW_W + 1)'(col_q) + (SZW_W + 1)'(1);
        row_inc = (SZH_W + 1)'(row_q) + (SZH_W + 1)'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (act0) begin
            if (line_first) begin
                col_q <= '0;
                if (frame_first || row_inc >= {1'b0, img_h})
                    row_q <= '0;
                else
                    row_q <= row_q + ROW_W'(1);
            end else if (col_inc >= {1'b0, img_w}) begin
                col_q <= '0;
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end

    // R7: after a visible step the column is zero or below the width in force
    a_r7_col_below_width: assert property (@(posedge clk) disable iff (!rst_n)
        act0 |=> (col_q == '0) || ((SZW_W + 1)'(col_q) < {1'b0, $past(img_w)}));

    // R8: the first visible line of a frame requests row zero
    a_r8_row_zero_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (act0 && frame_first) |=> (row_q == '0));
endmodule

// File: rtl/vtg_video_timer.sv
module vtg_video_timer
    import vtg_pkg::*;
#(
    parameter int H_ACT    = 800,
    parameter int H_FP     = 40,
    parameter int H_SW     = 128,
    parameter int H_BP     = 88,
    parameter int V_ACT    = 600,
    parameter int V_FP     = 1,
    parameter int V_SW     = 4,
    parameter int V_BP     = 23,
    parameter int CW       = 8,
    parameter bit SYNC_POS = 1'b1,
    localparam int SZW_W   = $clog2(H_ACT + 1),
    localparam int SZH_W   = $clog2(V_ACT + 1),
    localparam int COL_W   = $clog2(H_ACT),
    localparam int ROW_W   = $clog2(V_ACT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SZW_W-1:0]  img_width,
    input  logic [SZH_W-1:0]  img_height,
    output logic              pix_req,
    output logic [COL_W-1:0]  pix_col,
    output logic [ROW_W-1:0]  pix_row,
    input  logic              pix_valid,
    input  logic [3*CW-1:0]   pix_data,
    output logic [CW-1:0]     red_o,
    output logic [CW-1:0]     green_o,
    output logic [CW-1:0]     blue_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              blank_o
);
    phase_e h_phase, v_phase;
    logic   h_first, v_first, h_wrap, v_wrap;
    logic   act0, hs0, vs0;
    logic   hs1, vs1;
    logic [3*CW-1:0] color_q;

    vtg_axis #(.ACT(H_ACT), .FP(H_FP), .SW(H_SW), .BP(H_BP)) u_haxis (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .phase_o(h_phase), .first_o(h_first), .wrap_o(h_wrap)
    );

    vtg_axis #(.ACT(V_ACT), .FP(V_FP), .SW(V_SW), .BP(V_BP)) u_vaxis (
        .clk(clk), .rst_n(rst_n), .step(h_wrap),
        .phase_o(v_phase), .first_o(v_first), .wrap_o(v_wrap)
    );

    always_comb begin
        act0 = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        hs0  = (h_phase == PH_SYNC);
        vs0  = (v_phase == PH_SYNC);
    end

    vtg_tile #(.COL_W(COL_W), .ROW_W(ROW_W), .SZW_W(SZW_W), .SZH_W(SZH_W)) u_tile (
        .clk(clk), .rst_n(rst_n), .act0(act0),
        .line_first(h_first), .frame_first(v_first && !v_wrap),
        .img_w(img_width), .img_h(img_height),
        .col_q(pix_col), .row_q(pix_row)
    );

    // request stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_req <= 1'b0;
            hs1     <= 1'b0;
            vs1     <= 1'b0;
        end else begin
            pix_req <= act0;
            hs1     <= hs0;
            vs1     <= vs0;
        end
    end

    // output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color_q <= '0;
            hsync_o <= ~SYNC_POS;
            vsync_o <= ~SYNC_POS;
            blank_o <= 1'b1;
        end else begin
            color_q <= (pix_req && pix_valid) ? pix_data : '0;
            hsync_o <= SYNC_POS ? hs1 : ~hs1;
            vsync_o <= SYNC_POS ? vs1 : ~vs1;
            blank_o <= ~pix_req;
        end
    end

    always_comb begin
        red_o   = color_q[3*CW-1:2*CW];
        green_o = color_q[2*CW-1:CW];
        blue_o  = color_q[CW-1:0];
    end

    // R6: a request is followed by a visible output cycle
    a_r6_req_then_visible: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> !blank_o);
    // R6: no request is followed by a blank output cycle
    a_r6_idle_then_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_req |=> blank_o);
    // R4: colours are black while blanked
    a_r4_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> (red_o == '0 && green_o == '0 && blue_o == '0));
    // R9: an unanswered request shows black
    a_r9_invalid_black: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !pix_valid) |=> (color_q == '0));
    // R2: hsync never overlaps visible output
    a_r2_hsync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o == SYNC_POS) |-> blank_o);
endmodule

// File: tb/vtg_video_timer_test.sv
module vtg_video_timer_test;
    localparam int H_ACT = 8, H_FP = 2, H_SW = 3, H_BP = 2;
    localparam int V_ACT = 6, V_FP = 1, V_SW = 2, V_BP = 1;
    localparam int CW    = 4;
    localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    img_width = 4'd3;
    logic [2:0]    img_height = 3'd4;
    logic          pix_req;
    logic [2:0]    pix_col, pix_row;
    logic          pix_valid = 1'b0;
    logic [11:0]   pix_data = 12'h000;
    logic [CW-1:0] red_o, green_o, blue_o;
    logic          hsync_o, vsync_o, blank_o;

    int  total = 0, bad = 0;
    bit  drop_en = 1'b0;
    bit  done = 1'b0;
    logic [11:0] sb[$];

    vtg_video_timer #(.H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
                      .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
                      .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .img_width(img_width), .img_height(img_height),
        .pix_req(pix_req), .pix_col(pix_col), .pix_row(pix_row),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // driver + scoreboard monitor
    initial begin
        int cyc = 0, seq = 0, x = 0, y = 0;
        int hs_rise = -1, hs_fall = -1, vs_rise = -1, blank_fall = -1;
        int vis_cnt = 0, lines = 0;
        bit first_line = 1'b1, prev_req = 1'b0;
        bit hs_p = 1'b0, vs_p = 1'b0, bl_p = 1'b1;
        logic [11:0] got, exp;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                sb.delete();
                pix_valid = 1'b0;
                continue;
            end
            cyc++;
            got = {red_o, green_o, blue_o};
            // scoreboard pop side
            if (!blank_o) begin
                vis_cnt++;
                if (sb.size() == 0) check(1'b0, "R6 visible without request", 0, 1);
                else begin
                    exp = sb.pop_front();
                    check(got == exp, "R5/R9 pixel colour", int'(got), int'(exp));
                end
            end else begin
                check(sb.size() == 0, "R6 blank while pixel pending", sb.size(), 0);
                check(got == 12'h000, "R4 colour in blank", int'(got), 0);
            end
            // horizontal timing
            if (hsync_o && !hs_p) begin
                if (hs_rise >= 0) check(cyc - hs_rise == H_TOT, "R2 line period", cyc - hs_rise, H_TOT);
                hs_rise = cyc;
            end
            if (!hsync_o && hs_p) begin
                check(cyc - hs_rise == H_SW, "R2 hsync width", cyc - hs_rise, H_SW);
                hs_fall = cyc;
            end
            if (!blank_o && bl_p) begin
                if (hs_fall >= 0) check(cyc - hs_fall == H_BP, "R2 back porch", cyc - hs_fall, H_BP);
                blank_fall = cyc;
                lines++;
                vis_cnt = 1;
            end
            if (blank_o && !bl_p && blank_fall >= 0)
                check(vis_cnt == H_ACT, "R1 pixels per line", vis_cnt, H_ACT);
            // vertical timing
            if (vsync_o && !vs_p) begin
                if (vs_rise >= 0) begin
                    check(cyc - vs_rise == H_TOT * V_TOT, "R3 frame period", cyc - vs_rise, H_TOT * V_TOT);
                    check(lines == V_ACT, "R1 lines per frame", lines, V_ACT);
                end
                vs_rise = cyc;
                lines = 0;
                first_line = 1'b1;
            end
            if (!vsync_o && vs_p)
                check(cyc - vs_rise == V_SW * H_TOT, "R3 vsync width", cyc - vs_rise, V_SW * H_TOT);
            hs_p = hsync_o; vs_p = vsync_o; bl_p = blank_o;
            // request side: model coordinates, answer, push expectation
            if (pix_req) begin
                int w, h;
                bit v;
                if (!prev_req) begin
                    x = 0;
                    if (first_line) begin y = 0; first_line = 1'b0; end
                    else y++;
                end
                w = (img_width == 0) ? 1 : int'(img_width);
                h = (img_height == 0) ? 1 : int'(img_height);
                check(int'(pix_col) == x % w, "R7 column tiling", int'(pix_col), x % w);
                check(int'(pix_row) == y % h, "R8 row tiling", int'(pix_row), y % h);
                v = !(drop_en && (seq % 7 == 3));
                pix_valid = v;
                pix_data  = {pix_col[2:0], 1'b1, pix_row[2:0], 1'b0, 4'(seq)};
                sb.push_back(v ? pix_data : 12'h000);
                seq++;
                x++;
            end else begin
                pix_valid = 1'b1;
                pix_data  = 12'hABC;
            end
            prev_req = pix_req;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    // main sequence
    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check(pix_req == 1'b0, "R10 request in reset", int'(pix_req), 0);
        check(blank_o == 1'b1, "R10 blank in reset", int'(blank_o), 1);
        check(hsync_o == 1'b0, "R10 hsync in reset", int'(hsync_o), 0);
        check(vsync_o == 1'b0, "R10 vsync in reset", int'(vsync_o), 0);
        check({red_o, green_o, blue_o} == 12'h000, "R10 colour in reset",
              int'({red_o, green_o, blue_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge vsync_o);
        img_width = 4'd8; img_height = 3'd6;           // image equals visible area
        repeat (2) @(posedge vsync_o);
        img_width = 4'd5; img_height = 3'd2; drop_en = 1'b1;  // R9 drops with mid-line wraps
        repeat (2) @(posedge vsync_o);
        img_width = 4'd1; img_height = 3'd1;           // R7 R8 every pixel is a wrap point
        repeat (2) @(posedge vsync_o);
        img_width = 4'd15; img_height = 3'd7; drop_en = 1'b0; // larger than visible area
        repeat (2) @(posedge vsync_o);
        img_width = 4'd0; img_height = 3'd0;           // zero sizes act as one
        repeat (2) @(posedge vsync_o);
        done = 1'b1;
        finish_run();
    end
endmodule